// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-on to a usable state. While the supply and clock are not yet trusted, it holds the clock-enable pin low and drives only a no-operation code. A "supply and clock stable" input starts a start-up wait. That wait must run for a number of consecutive stable cycles, computed from a clock-frequency parameter and a wait length given in microseconds. After the wait, the block raises clock enable and issues a fixed bring-up sequence. It precharges all banks and turns on the DLL through the extended mode register. It then loads the base mode register with a DLL reset, precharges again, and runs two auto refreshes. Last, it rewrites the base mode register with the DLL reset bit cleared.

Between commands the block holds no-operation for parameterized spacings: precharge-to-command, mode-register-to-command and refresh-to-command. Two flags leave the block. `init_done` reports that the bring-up is complete. `dll_locked` is timed on its own from the DLL-reset write, and the read path uses it to hold back reads. An asynchronous reset at any point returns the block to the clock-enable-low wait and clears both flags.

Top module: `ddr_boot_seq`

## Requirements
- R1: While reset is active, and at every cycle in which `cke` is low, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-operation), and `init_done` and `dll_locked` are 0.
- R2: `cke` rises exactly WAIT_CYC = CLK_MHZ*STARTUP_US cycles after the first cycle of an unbroken run of `supply_ok` high. Any cycle with `supply_ok` low restarts the count. With `supply_ok` held low, `cke` stays low and no command is issued.
- R3: The first cycle with `cke` high is a no-operation. The first precharge-all follows in the next cycle. From then on `cke` stays high until reset.
- R4: Command codes on {cs_n,ras_n,cas_n,we_n} are: precharge 4'b0010, auto refresh 4'b0001, mode register write 4'b0000. A precharge carries address 1<<10 (A10 high, all banks) and bank 0. A refresh carries address 0 and bank 0.
- R5: The extended mode register write comes T_RP cycles after the first precharge. It drives bank address 1 (BA0 high) and EXT_MODE_WORD with A0 forced low (DLL on).
- R6: The DLL-reset mode register write comes T_MRD cycles after the extended write. It drives bank 0 and MODE_WORD with A8 forced high.
- R7: The second precharge-all comes T_MRD cycles after the DLL-reset write. The first refresh comes T_RP cycles after that, and the second refresh T_RFC cycles after the first. No more than two refreshes are issued.
- R8: The final mode register write comes T_RFC cycles after the second refresh. It drives bank 0 and MODE_WORD with A8 forced low. `init_done` rises T_MRD cycles later and stays high. Exactly seven commands are issued per bring-up, and none after `init_done`.
- R9: `dll_locked` rises exactly LOCK_CYC cycles after the DLL-reset mode register write and stays high until reset.
- R10: Reset at any point in the sequence, before or after completion, at once forces `cke` low and the no-operation code and clears `init_done` and `dll_locked`. The next bring-up runs in full again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply and clock stable |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Bring-up complete |
| dll_locked | output | 1 | DLL lock time elapsed; reads allowed |

## Verification
The cases hardest to reach from the ports are a break in the stable run that lands late in the start-up wait, and a reset that lands in the middle of a command gap or after the sequence has ended. Both need stimulus placed at exact cycle offsets from the last rise of `supply_ok`. The bench uses a small start-up wait. It sweeps the break position across the wait, including one cycle short of completion. It also sweeps the reset instant across the whole sequence and beyond the DLL lock point. Every command cycle and both flag rise times are computed from the spacing parameters, relative to the restarted stable edge.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [4:0] {
      ST_HOLD, ST_WAKE,
      ST_PRE_A, ST_GAP_A,
      ST_EMRS, ST_GAP_B,
      ST_MRS_DLL, ST_GAP_C,
      ST_PRE_B, ST_GAP_D,
      ST_REF_A, ST_GAP_E,
      ST_REF_B, ST_GAP_F,
      ST_MRS_OP, ST_GAP_G,
      ST_READY
   } step_e;

   typedef enum logic [1:0] {OP_NOP, OP_PRE, OP_REF, OP_MRS} op_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pins_t;

   function automatic pins_t op_pins(op_e op);
      pins_t p;
      case (op)
         OP_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         OP_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         OP_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
         default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/dbs_countdown.sv
module dbs_countdown #(
   parameter int CW   = 8,
   parameter int INIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= CW'(INIT);
      else if (load)             cnt <= load_val;
      else if (dec && cnt != '0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/dbs_lock_timer.sv
module dbs_lock_timer #(
   parameter int LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic locked
);
   localparam int LW = $clog2(LOCK_CYC + 1);

   logic [LW-1:0] cnt;
   logic          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         run    <= 1'b0;
         locked <= 1'b0;
      end else if (start) begin
         cnt <= LW'(1);
         run <= 1'b1;
      end else if (run && !locked) begin
         cnt <= cnt + 1'b1;
         if (cnt == LW'(LOCK_CYC - 1)) begin
            locked <= 1'b1;
            run    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dbs_bus_drive.sv
module dbs_bus_drive
   import dbs_pkg::*;
#(
   parameter int                ADDR_W        = 13,
   parameter int                BA_W          = 2,
   parameter logic [ADDR_W-1:0] MODE_WORD     = '0,
   parameter logic [ADDR_W-1:0] EXT_MODE_WORD = '0
) (
   input  step_e             step,
   output pins_t             pins,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] BIT_A0  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] BIT_A8  = ADDR_W'(1) << 8;
   localparam logic [ADDR_W-1:0] BIT_A10 = ADDR_W'(1) << 10;

   always_comb begin
      pins = op_pins(OP_NOP);
      ba   = '0;
      addr = '0;
      case (step)
         ST_PRE_A, ST_PRE_B: begin
            pins = op_pins(OP_PRE);
            addr = BIT_A10;
         end
         ST_REF_A, ST_REF_B: pins = op_pins(OP_REF);
         ST_EMRS: begin
            pins = op_pins(OP_MRS);
            ba   = BA_W'(1);
            addr = EXT_MODE_WORD & ~BIT_A0;
         end
         ST_MRS_DLL: begin
            pins = op_pins(OP_MRS);
            addr = MODE_WORD | BIT_A8;
         end
         ST_MRS_OP: begin
            pins = op_pins(OP_MRS);
            addr = MODE_WORD & ~BIT_A8;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ddr_boot_seq.sv
module ddr_boot_seq
   import dbs_pkg::*;
#(
   parameter int                ADDR_W        = 13,
   parameter int                BA_W          = 2,
   parameter int                CLK_MHZ       = 250,
   parameter int                STARTUP_US    = 200,
   parameter int                T_RP          = 3,
   parameter int                T_MRD         = 2,
   parameter int                T_RFC         = 18,
   parameter int                LOCK_CYC      = 200,
   parameter logic [ADDR_W-1:0] MODE_WORD     = ADDR_W'(13'h0032),
   parameter logic [ADDR_W-1:0] EXT_MODE_WORD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done,
   output logic              dll_locked
);
   localparam int WAIT_CYC = CLK_MHZ * STARTUP_US;
   localparam int GAP_MAX  = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
   localparam int SPAN_MAX = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
   localparam int CW       = $clog2(SPAN_MAX + 1);

   localparam logic [CW-1:0] LD_WAIT = CW'(WAIT_CYC - 1);
   localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 2);
   localparam logic [CW-1:0] LD_MRD  = CW'(T_MRD - 2);
   localparam logic [CW-1:0] LD_RFC  = CW'(T_RFC - 2);

   generate
      if (ADDR_W < 11)
         $error("ddr_boot_seq: ADDR_W must reach the A10 bit");
      if (BA_W < 1)
         $error("ddr_boot_seq: BA_W must be at least 1");
      if (WAIT_CYC < 2)
         $error("ddr_boot_seq: start-up wait must be at least 2 cycles");
      if (T_RP < 2 || T_MRD < 2 || T_RFC < 2)
         $error("ddr_boot_seq: command spacings must be at least 2 cycles");
      if (LOCK_CYC < 2)
         $error("ddr_boot_seq: LOCK_CYC must be at least 2");
   endgenerate

   step_e         st, st_nxt;
   logic          cnt_load, cnt_dec, cnt_zero;
   logic [CW-1:0] cnt_val;
   pins_t         pins;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_HOLD;
      else        st <= st_nxt;
   end

   always_comb begin
      st_nxt   = st;
      cnt_load = 1'b0;
      cnt_val  = '0;
      cnt_dec  = 1'b0;
      case (st)
         ST_HOLD: begin
            if (!supply_ok) begin
               cnt_load = 1'b1;
               cnt_val  = LD_WAIT;
            end else if (cnt_zero) begin
               st_nxt = ST_WAKE;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         ST_WAKE:    st_nxt = ST_PRE_A;
         ST_PRE_A:   begin st_nxt = ST_GAP_A; cnt_load = 1'b1; cnt_val = LD_RP;  end
         ST_EMRS:    begin st_nxt = ST_GAP_B; cnt_load = 1'b1; cnt_val = LD_MRD; end
         ST_MRS_DLL: begin st_nxt = ST_GAP_C; cnt_load = 1'b1; cnt_val = LD_MRD; end
         ST_PRE_B:   begin st_nxt = ST_GAP_D; cnt_load = 1'b1; cnt_val = LD_RP;  end
         ST_REF_A:   begin st_nxt = ST_GAP_E; cnt_load = 1'b1; cnt_val = LD_RFC; end
         ST_REF_B:   begin st_nxt = ST_GAP_F; cnt_load = 1'b1; cnt_val = LD_RFC; end
         ST_MRS_OP:  begin st_nxt = ST_GAP_G; cnt_load = 1'b1; cnt_val = LD_MRD; end
         ST_GAP_A:   if (cnt_zero) st_nxt = ST_EMRS;    else cnt_dec = 1'b1;
         ST_GAP_B:   if (cnt_zero) st_nxt = ST_MRS_DLL; else cnt_dec = 1'b1;
         ST_GAP_C:   if (cnt_zero) st_nxt = ST_PRE_B;   else cnt_dec = 1'b1;
         ST_GAP_D:   if (cnt_zero) st_nxt = ST_REF_A;   else cnt_dec = 1'b1;
         ST_GAP_E:   if (cnt_zero) st_nxt = ST_REF_B;   else cnt_dec = 1'b1;
         ST_GAP_F:   if (cnt_zero) st_nxt = ST_MRS_OP;  else cnt_dec = 1'b1;
         ST_GAP_G:   if (cnt_zero) st_nxt = ST_READY;   else cnt_dec = 1'b1;
         default:    st_nxt = ST_READY;
      endcase
   end

   dbs_countdown #(.CW(CW), .INIT(WAIT_CYC - 1)) u_span (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .zero     (cnt_zero)
   );

   dbs_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (st == ST_MRS_DLL),
      .locked (dll_locked)
   );

   dbs_bus_drive #(
      .ADDR_W        (ADDR_W),
      .BA_W          (BA_W),
      .MODE_WORD     (MODE_WORD),
      .EXT_MODE_WORD (EXT_MODE_WORD)
   ) u_drive (
      .step (st),
      .pins (pins),
      .ba   (ba),
      .addr (addr)
   );

   assign cs_n      = pins.cs_n;
   assign ras_n     = pins.ras_n;
   assign cas_n     = pins.cas_n;
   assign we_n      = pins.we_n;
   assign cke       = (st != ST_HOLD);
   assign init_done = (st == ST_READY);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
   parameter int ADDR_W   = 13,
   parameter int BA_W     = 2,
   parameter int WAIT_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              supply_ok,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BA_W-1:0]   ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done,
   input logic              dll_locked
);
   logic [3:0]  code;
   logic [31:0] ok_run;
   logic [1:0]  ref_cnt;

   assign code = {cs_n, ras_n, cas_n, we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ok_run <= '0;
      else if (!supply_ok)                 ok_run <= '0;
      else if (!cke && ok_run != '1)       ok_run <= ok_run + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ref_cnt <= '0;
      else if (code == 4'b0001 && ref_cnt != 2'd3) ref_cnt <= ref_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clears_R10: assert (!cke && !init_done && !dll_locked && code == 4'b0111)
            else $error("reset did not clear outputs");
      end
   end

   assert_nop_while_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> code == 4'b0111);

   assert_startup_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> ok_run >= 32'(WAIT_CYC));

   assert_cke_stays_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   assert_precharge_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      code == 4'b0010 |-> (addr == (ADDR_W'(1) << 10) && ba == '0));

   assert_ext_dll_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 4'b0000 && ba == BA_W'(1)) |-> (addr & ADDR_W'(1)) == '0);

   assert_two_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cnt <= 2'd2);

   assert_done_after_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> ref_cnt == 2'd2);

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> (init_done && code == 4'b0111));

   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dll_locked |=> dll_locked);
endmodule

bind ddr_boot_seq dbs_checker #(
   .ADDR_W   (ADDR_W),
   .BA_W     (BA_W),
   .WAIT_CYC (WAIT_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .supply_ok  (supply_ok),
   .cke        (cke),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .ba         (ba),
   .addr       (addr),
   .init_done  (init_done),
   .dll_locked (dll_locked)
);

// File: tb/ddr_boot_seq_test.sv
`timescale 1ns/1ps
module ddr_boot_seq_test;
   localparam int ADDR_W = 13, BA_W = 2;
   localparam int CLK_MHZ = 1, STARTUP_US = 200, WAIT_CYC = CLK_MHZ * STARTUP_US;
   localparam int T_RP = 3, T_MRD = 2, T_RFC = 7, LOCK_CYC = 200;
   localparam logic [ADDR_W-1:0] MODE = 13'h0162, EMODE = 13'h0003;

   logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, init_done, dll_locked;
   logic [BA_W-1:0]   ba;
   logic [ADDR_W-1:0] addr;

   ddr_boot_seq #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .CLK_MHZ(CLK_MHZ), .STARTUP_US(STARTUP_US),
      .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .LOCK_CYC(LOCK_CYC),
      .MODE_WORD(MODE), .EXT_MODE_WORD(EMODE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cke(cke),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .init_done(init_done), .dll_locked(dll_locked)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;
   int n_ev, cke_cyc, done_cyc, lock_cyc;
   int ev_cyc [8];
   logic [3:0]        ev_code [8];
   logic [BA_W-1:0]   ev_ba   [8];
   logic [ADDR_W-1:0] ev_addr [8];

   always @(negedge clk) begin
      if (rst_n) begin
         if (cke && cke_cyc < 0) cke_cyc = cyc;
         if (init_done && done_cyc < 0) done_cyc = cyc;
         if (dll_locked && lock_cyc < 0) lock_cyc = cyc;
         if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
            if (n_ev < 8) begin
               ev_cyc[n_ev]  = cyc;
               ev_code[n_ev] = {cs_n, ras_n, cas_n, we_n};
               ev_ba[n_ev]   = ba;
               ev_addr[n_ev] = addr;
            end
            n_ev = n_ev + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_fresh();
      rst_n = 1'b0;
      supply_ok = 1'b0;
      n_ev = 0; cke_cyc = -1; done_cyc = -1; lock_cyc = -1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // expected command table relative to the cke rise cycle k
   task automatic verify_run(input int c0);
      int k, e_cyc[7], e_code[7], e_ba[7], e_addr[7];
      string rq[7];
      k = c0 + WAIT_CYC;
      chk(cke_cyc == k, "R2 cke rise cycle", cke_cyc, k);
      e_cyc[0] = k + 1;
      e_cyc[1] = e_cyc[0] + T_RP;
      e_cyc[2] = e_cyc[1] + T_MRD;
      e_cyc[3] = e_cyc[2] + T_MRD;
      e_cyc[4] = e_cyc[3] + T_RP;
      e_cyc[5] = e_cyc[4] + T_RFC;
      e_cyc[6] = e_cyc[5] + T_RFC;
      e_code = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
      e_ba   = '{0, 1, 0, 0, 0, 0, 0};
      e_addr = '{13'h0400, 13'h0002, 13'h0162, 13'h0400, 0, 0, 13'h0062};
      rq     = '{"R3", "R5", "R6", "R7", "R7", "R7", "R8"};
      chk(n_ev == 7, "R8 command count", n_ev, 7);
      for (int i = 0; i < 7; i++) begin
         chk(ev_cyc[i] == e_cyc[i], {rq[i], " command cycle"}, ev_cyc[i], e_cyc[i]);
         chk(int'(ev_code[i]) == e_code[i], {"R4 code for ", rq[i]}, ev_code[i], e_code[i]);
         chk(int'(ev_ba[i]) == e_ba[i], {rq[i], " bank"}, ev_ba[i], e_ba[i]);
         chk(int'(ev_addr[i]) == e_addr[i], {rq[i], " address"}, ev_addr[i], e_addr[i]);
      end
      chk(done_cyc == e_cyc[6] + T_MRD, "R8 init_done cycle", done_cyc, e_cyc[6] + T_MRD);
      chk(lock_cyc == e_cyc[2] + LOCK_CYC, "R9 dll_locked cycle", lock_cyc, e_cyc[2] + LOCK_CYC);
      chk(cke && init_done && dll_locked, "R3 flags held at end", {cke, init_done, dll_locked}, 3'b111);
   endtask

   task automatic full_run(input int glitch_at);
      int c0;
      start_fresh();
      supply_ok = 1'b1;
      c0 = cyc;
      if (glitch_at >= 0) begin
         repeat (glitch_at) @(negedge clk);
         supply_ok = 1'b0;
         @(negedge clk);
         supply_ok = 1'b1;
         c0 = cyc;
      end
      for (int i = 0; i < 1000; i++) begin
         if (init_done && dll_locked) break;
         @(negedge clk);
      end
      repeat (20) @(negedge clk);
      verify_run(c0);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int c0;
      // R1 and R10: state under reset
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!cke, "R1 cke under reset", cke, 0);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop under reset",
          {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      chk(!init_done && !dll_locked, "R10 flags under reset", {init_done, dll_locked}, 0);

      // R2: supply never stable
      start_fresh();
      repeat (WAIT_CYC + 100) @(negedge clk);
      chk(!cke, "R2 cke low without supply", cke, 0);
      chk(n_ev == 0, "R2 no command without supply", n_ev, 0);

      // full sequences with breaks at several points of the wait
      full_run(-1);
      full_run(0);
      full_run(37);
      full_run(120);
      full_run(WAIT_CYC - 2);

      // R10: reset swept across the sequence and past lock
      for (int off = 0; off <= 260; off += 13) begin
         start_fresh();
         supply_ok = 1'b1;
         c0 = cyc;
         while (cyc < c0 + WAIT_CYC + off) @(negedge clk);
         rst_n = 1'b0;
         #0.5;
         chk(!cke, "R10 cke after mid reset", cke, 0);
         chk(!init_done && !dll_locked, "R10 flags after mid reset",
             {init_done, dll_locked}, 0);
         chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10 nop after mid reset",
             {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      end

      // R10: a complete bring-up after the resets
      full_run(-1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule